// File: doc/BRIEF.md
# Exception Acceptance Arbiter

This block sits beside a processor core and decides which exception the core enters next. It watches the reset pin, a watchdog overflow flag, execution-time fault flags, the trace enable and interrupt control mode, the interrupt request line, the sleep and trap strobes, the two standby control bits, and a small code naming the instruction that just retired. Each source has its own rule for when its request becomes eligible. Requests are latched, and the eligible one with the highest priority is handed to the core as a one-hot select, an encoded number and a single-cycle start pulse.

After a start the arbiter is busy. It makes no new choice until the core reports that the entry sequence has finished. Requests that lost arbitration stay latched and are served one after another in priority order. Two events count as a boundary: the retirement of an instruction (`insn_done`) and the end of an exception entry (`entry_done`). At a boundary the trace and interrupt requests are sampled.

Top module: `exc_arbiter`

## Requirements
- R1: While `res_n` is low, `in_reset` is 1, `exc_start` is 0, `exc_sel` is 0 and `exc_code` is 7, and strobes seen in that time are dropped. In the first cycle after `res_n` is sampled high, a start with code 0 (reset) is issued. Pulling `res_n` low during an entry abandons that entry.
- R2: A pulse on `wdt_ovf` leads to a reset start (code 0) two clocks later. Accepting a reset discards every other pending request.
- R3: Exception codes are fixed as reset 0, illegal 1, trace 2, address error 3, interrupt 4, sleep 5 and trap 6. `exc_sel` bit i corresponds to code i, and code 7 means none. When several requests are eligible, the lowest code wins.
- R4: A request that loses arbitration stays pending. After each `entry_done` the next eligible request starts, so pending requests are served in code order.
- R5: `exc_start` is high for exactly one cycle. `exc_sel` is one-hot from the start until the cycle `entry_done` is sampled, and it stays constant over that interval. No start occurs while an entry is in progress.
- R6: An illegal-opcode flag needs no boundary. When the block is idle and nothing else is pending, the start (code 1) follows two clocks after the flag.
- R7: An address-error flag is held. It becomes eligible only when `insn_done` is sampled, either in the same cycle as the flag or in a later cycle.
- R8: Trace is requested at a boundary only when `trace_en` is 1 and `int_mode` equals 2. It is not requested when the retired instruction code is 1 (return from exception).
- R9: `irq` is sampled only at a boundary. It is not sampled when the retired code is 2, 3, 4 or 5 (the CCR-writing AND, OR, XOR and load instructions), nor at the end of a reset entry.
- R10: `sleep_exec` creates a request only when `sby_soft` is 0 and `sby_slp_ie` is 1. Sleep and trap strobes are latched in any cycle outside reset, including while an entry is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Reset pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| ill_op | input | 1 | Undefined opcode executed |
| addr_err | input | 1 | Address error detected |
| insn_done | input | 1 | Instruction retired this cycle |
| retired_op | input | 3 | Class code of the retired instruction |
| trace_en | input | 1 | Trace bit |
| int_mode | input | 2 | Interrupt control mode |
| irq | input | 1 | Interrupt request level |
| sleep_exec | input | 1 | Sleep instruction executed |
| trap_exec | input | 1 | Trap instruction executed |
| sby_soft | input | 1 | Software standby select |
| sby_slp_ie | input | 1 | Sleep-exception enable |
| entry_done | input | 1 | Core finished the exception entry |
| in_reset | output | 1 | Core held in reset state |
| exc_start | output | 1 | One-cycle start strobe |
| exc_sel | output | 7 | One-hot selected exception |
| exc_code | output | 3 | Encoded selected exception, 7 when none |

## Verification
Latching and arbitration can fall in the same cycle. A request can arrive while another request is being granted, and several sources can qualify on the same boundary. The stimulus table provokes this by raising combinations such as illegal with trap and interrupt, trace with address error, or interrupt with sleep and trap on one retire cycle, and it checks that exactly the lowest code starts. A directed test builds up address-error, sleep and trap requests while an entry is in progress. It then releases `entry_done` repeatedly and checks that the starts come out in code order 3, 5, 6 with the select held steady between them.

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter #(
  parameter int OPW = 3,
  parameter int MODEW = 2,
  parameter logic [MODEW-1:0] TRACE_MODE = 2,
  parameter logic [OPW-1:0] OP_RTE = 1,
  parameter logic [OPW-1:0] OP_ANDC = 2,
  parameter logic [OPW-1:0] OP_ORC = 3,
  parameter logic [OPW-1:0] OP_XORC = 4,
  parameter logic [OPW-1:0] OP_LDCCR = 5
) (
  input  logic             clk,
  input  logic             res_n,
  input  logic             wdt_ovf,
  input  logic             ill_op,
  input  logic             addr_err,
  input  logic             insn_done,
  input  logic [OPW-1:0]   retired_op,
  input  logic             trace_en,
  input  logic [MODEW-1:0] int_mode,
  input  logic             irq,
  input  logic             sleep_exec,
  input  logic             trap_exec,
  input  logic             sby_soft,
  input  logic             sby_slp_ie,
  input  logic             entry_done,
  output logic             in_reset,
  output logic             exc_start,
  output logic [6:0]       exc_sel,
  output logic [2:0]       exc_code
);
  localparam int NX = 7;
  localparam int CW = $clog2(NX + 1);
  localparam int X_RST = 0, X_ILL = 1, X_TRC = 2, X_AE = 3, X_IRQ = 4, X_SLP = 5, X_TRP = 6;

  logic [NX-1:0] pend, pend_nx, gnt, clr;
  logic [NX-1:0] sel_q;
  logic          ae_raw, busy, start_q;

  wire entry_end = entry_done & busy;
  wire boundary  = insn_done | entry_end;
  wire ccr_write = insn_done & (retired_op == OP_ANDC || retired_op == OP_ORC ||
                                retired_op == OP_XORC || retired_op == OP_LDCCR);
  wire rte_done  = insn_done & (retired_op == OP_RTE);
  wire rst_end   = entry_end & sel_q[X_RST];
  wire trc_hit   = boundary & trace_en & (int_mode == TRACE_MODE) & ~rte_done;
  wire irq_ok    = irq & ~ccr_write & ~rst_end;
  wire take      = ~busy & (|pend);

  assign gnt = pend & (~pend + 1'b1);
  assign clr = take ? (gnt[X_RST] ? {NX{1'b1}} : gnt) : '0;

  always_comb begin
    pend_nx = pend & ~clr;
    pend_nx[X_RST] = pend_nx[X_RST] | wdt_ovf;
    pend_nx[X_ILL] = pend_nx[X_ILL] | ill_op;
    pend_nx[X_TRC] = pend_nx[X_TRC] | trc_hit;
    pend_nx[X_AE]  = pend_nx[X_AE] | (insn_done & (ae_raw | addr_err) & ~(take & gnt[X_RST]));
    pend_nx[X_SLP] = pend_nx[X_SLP] | (sleep_exec & ~sby_soft & sby_slp_ie);
    pend_nx[X_TRP] = pend_nx[X_TRP] | trap_exec;
    if (boundary) pend_nx[X_IRQ] = irq_ok;
  end

  always_ff @(posedge clk) begin
    if (!res_n) begin
      pend    <= NX'(1);
      ae_raw  <= 1'b0;
      busy    <= 1'b0;
      sel_q   <= '0;
      start_q <= 1'b0;
    end else begin
      pend    <= pend_nx;
      start_q <= take;
      if (take && gnt[X_RST]) ae_raw <= 1'b0;
      else if (insn_done)     ae_raw <= 1'b0;
      else if (addr_err)      ae_raw <= 1'b1;
      if (take) begin
        busy  <= 1'b1;
        sel_q <= gnt;
      end else if (entry_end) begin
        busy  <= 1'b0;
        sel_q <= '0;
      end
    end
  end

  always_comb begin
    exc_code = '1;
    for (int i = NX - 1; i >= 0; i--)
      if (sel_q[i]) exc_code = CW'(i);
  end

  assign in_reset  = ~res_n;
  assign exc_start = start_q;
  assign exc_sel   = sel_q;
endmodule

// File: rtl/exc_arbiter_chk.sv
`timescale 1ns/1ps
module exc_arbiter_chk #(
  parameter int OPW = 3,
  parameter logic [OPW-1:0] OP_RTE = 1,
  parameter logic [OPW-1:0] OP_ANDC = 2,
  parameter logic [OPW-1:0] OP_ORC = 3,
  parameter logic [OPW-1:0] OP_XORC = 4,
  parameter logic [OPW-1:0] OP_LDCCR = 5
) (
  input logic           clk,
  input logic           res_n,
  input logic           wdt_ovf,
  input logic           ill_op,
  input logic           addr_err,
  input logic           insn_done,
  input logic [OPW-1:0] retired_op,
  input logic           sleep_exec,
  input logic           sby_soft,
  input logic           sby_slp_ie,
  input logic           entry_done,
  input logic           exc_start,
  input logic [6:0]     exc_sel,
  input logic           busy,
  input logic [6:0]     pend
);
  wire ccr_op = (retired_op == OP_ANDC) || (retired_op == OP_ORC) ||
                (retired_op == OP_XORC) || (retired_op == OP_LDCCR);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !res_n |=> (!exc_start && exc_sel == 7'd0));

  a_r1_release_start: assert property (@(posedge clk)
    $rose(res_n) |=> (exc_start && exc_sel == 7'b0000001));

  a_r2_wdt_reset: assert property (@(posedge clk) disable iff (!res_n)
    (wdt_ovf && !busy && pend == 7'd0) |=> ##1 (exc_start && exc_sel[0]));

  a_r3_reset_wins: assert property (@(posedge clk) disable iff (!res_n)
    (!busy && pend[0]) |=> (exc_start && exc_sel == 7'b0000001));

  a_r3_illegal_over_rest: assert property (@(posedge clk) disable iff (!res_n)
    (!busy && pend[1] && !pend[0]) |=> (exc_start && exc_sel == 7'b0000010));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!res_n)
    exc_start |=> !exc_start);

  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!res_n)
    exc_start |-> $countones(exc_sel) == 1);

  a_r5_sel_hold: assert property (@(posedge clk) disable iff (!res_n)
    (exc_sel != 7'd0 && !entry_done) |=> ($stable(exc_sel) && !exc_start));

  a_r6_illegal_fast: assert property (@(posedge clk) disable iff (!res_n)
    (ill_op && !busy && pend == 7'd0 && !wdt_ovf) |=> ##1 (exc_start && exc_sel == 7'b0000010));

  a_r7_ae_waits: assert property (@(posedge clk) disable iff (!res_n)
    (addr_err && !insn_done && !pend[3]) |=> ##1 !(exc_start && exc_sel[3]));

  a_r8_no_trace_after_rte: assert property (@(posedge clk) disable iff (!res_n)
    (insn_done && retired_op == OP_RTE && !entry_done && !pend[2]) |=> ##1 !(exc_start && exc_sel[2]));

  a_r9_ccr_masks_irq: assert property (@(posedge clk) disable iff (!res_n)
    (insn_done && ccr_op) |=> ##1 !(exc_start && exc_sel[4]));

  a_r10_sleep_gate: assert property (@(posedge clk) disable iff (!res_n)
    (sleep_exec && (sby_soft || !sby_slp_ie) && !pend[5]) |=> ##1 !(exc_start && exc_sel[5]));
endmodule

bind exc_arbiter exc_arbiter_chk #(
  .OPW(OPW), .OP_RTE(OP_RTE), .OP_ANDC(OP_ANDC), .OP_ORC(OP_ORC),
  .OP_XORC(OP_XORC), .OP_LDCCR(OP_LDCCR)
) u_chk (
  .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .ill_op(ill_op), .addr_err(addr_err),
  .insn_done(insn_done), .retired_op(retired_op), .sleep_exec(sleep_exec),
  .sby_soft(sby_soft), .sby_slp_ie(sby_slp_ie), .entry_done(entry_done),
  .exc_start(exc_start), .exc_sel(exc_sel), .busy(busy), .pend(pend)
);

// File: tb/tb_exc_arbiter.sv
`timescale 1ns/1ps
module tb_exc_arbiter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       res_n = 1'b0, wdt_ovf = 1'b0, ill_op = 1'b0, addr_err = 1'b0;
  logic       insn_done = 1'b0, trace_en = 1'b0, irq = 1'b0, sleep_exec = 1'b0;
  logic       trap_exec = 1'b0, sby_soft = 1'b0, sby_slp_ie = 1'b0, entry_done = 1'b0;
  logic [2:0] retired_op = 3'd0;
  logic [1:0] int_mode = 2'd0;
  logic       in_reset, exc_start;
  logic [6:0] exc_sel;
  logic [2:0] exc_code;

  exc_arbiter dut (
    .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .ill_op(ill_op), .addr_err(addr_err),
    .insn_done(insn_done), .retired_op(retired_op), .trace_en(trace_en), .int_mode(int_mode),
    .irq(irq), .sleep_exec(sleep_exec), .trap_exec(trap_exec), .sby_soft(sby_soft),
    .sby_slp_ie(sby_slp_ie), .entry_done(entry_done), .in_reset(in_reset),
    .exc_start(exc_start), .exc_sel(exc_sel), .exc_code(exc_code)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // fields: ill ae done op[2:0] trc mode[1:0] irq slp trp ssby slpie pad[1:0] expected_code[2:0]
  localparam int NV = 22;
  localparam logic [18:0] VEC [NV] = '{
    19'b1_0_0_000_0_00_0_0_0_0_0_00_001, // R6 illegal alone
    19'b0_1_0_000_0_00_0_0_0_0_0_00_111, // R7 address error without retire
    19'b0_1_1_000_0_00_0_0_0_0_0_00_011, // R7 address error with retire
    19'b0_0_1_000_1_10_0_0_0_0_0_00_010, // R8 trace in mode 2
    19'b0_0_1_000_1_00_0_0_0_0_0_00_111, // R8 trace in mode 0
    19'b0_0_1_001_1_10_0_0_0_0_0_00_111, // R8 no trace after return
    19'b0_0_1_000_0_00_1_0_0_0_0_00_100, // R9 interrupt at retire
    19'b0_0_1_010_0_00_1_0_0_0_0_00_111, // R9 masked after AND-to-CCR
    19'b0_0_1_101_0_00_1_0_0_0_0_00_111, // R9 masked after load-to-CCR
    19'b0_0_0_000_0_00_1_0_0_0_0_00_111, // R9 not sampled off-boundary
    19'b0_0_0_000_0_00_0_1_0_0_1_00_101, // R10 sleep enabled
    19'b0_0_0_000_0_00_0_1_0_1_1_00_111, // R10 sleep with soft standby
    19'b0_0_0_000_0_00_0_1_0_0_0_00_111, // R10 sleep without enable
    19'b0_0_0_000_0_00_0_0_1_0_0_00_110, // R10 trap alone
    19'b1_0_1_000_0_00_1_0_1_0_0_00_001, // R3 illegal over interrupt and trap
    19'b0_1_1_000_1_10_0_0_0_0_0_00_010, // R3 trace over address error
    19'b0_1_1_000_0_00_1_0_0_0_0_00_011, // R3 address error over interrupt
    19'b0_0_1_000_0_00_1_1_1_0_1_00_100, // R3 interrupt over sleep and trap
    19'b0_0_0_000_0_00_0_1_1_0_1_00_101, // R3 sleep over trap
    19'b0_0_1_100_0_00_1_0_1_0_0_00_110, // R9 XOR-to-CCR masks irq, trap left
    19'b0_0_1_011_0_00_1_0_0_0_0_00_111, // R9 masked after OR-to-CCR
    19'b0_0_1_000_1_01_0_0_0_0_0_00_111  // R8 trace in mode 1
  };
  localparam int VREQ [NV] = '{6,7,7,8,8,8,9,9,9,9,10,10,10,10,3,3,3,3,3,9,9,8};

  task automatic expect_out(input string tag, input logic st, input logic [2:0] code);
    checks++;
    if (exc_start !== st || exc_code !== code) begin
      errors++;
      $display("FAIL %s: start/code actual %b/%0d expected %b/%0d", tag, exc_start, exc_code, st, code);
    end
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wdt_ovf = 0; ill_op = 0; addr_err = 0; insn_done = 0; retired_op = 0; trace_en = 0;
    int_mode = 0; irq = 0; sleep_exec = 0; trap_exec = 0; sby_soft = 0; sby_slp_ie = 0;
    entry_done = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 24; i++) begin
      if (i == 0) insn_done = 1;
      if (exc_start) entry_done = 1;
      @(negedge clk);
      insn_done = 0;
      entry_done = 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (2) @(negedge clk);
    trap_exec = 1;
    @(negedge clk);
    trap_exec = 0;
    expect_bit("R1 in_reset while pin low", in_reset, 1'b1);
    expect_out("R1 quiet while pin low", 1'b0, 3'd7);

    res_n = 1;
    @(negedge clk);
    expect_bit("R1 in_reset released", in_reset, 1'b0);
    expect_out("R1 reset start on release", 1'b1, 3'd0);
    irq = 1; entry_done = 1;
    @(negedge clk);
    entry_done = 0;
    @(negedge clk);
    expect_out("R9 no irq after reset entry, R1 trap dropped", 1'b0, 3'd7);
    insn_done = 1;
    @(negedge clk);
    insn_done = 0; irq = 0;
    @(negedge clk);
    expect_out("R9 irq at later retire", 1'b1, 3'd4);
    drain();

    for (int k = 0; k < NV; k++) begin
      logic [18:0] v;
      v = VEC[k];
      ill_op = v[18]; addr_err = v[17]; insn_done = v[16]; retired_op = v[15:13];
      trace_en = v[12]; int_mode = v[11:10]; irq = v[9]; sleep_exec = v[8];
      trap_exec = v[7]; sby_soft = v[6]; sby_slp_ie = v[5];
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      expect_out($sformatf("R%0d vector %0d", VREQ[k], k), v[2:0] != 3'd7, v[2:0]);
      drain();
    end

    wdt_ovf = 1; trap_exec = 1;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    expect_out("R2 watchdog reset start", 1'b1, 3'd0);
    entry_done = 1;
    @(negedge clk);
    entry_done = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_out("R2 trap discarded by reset", 1'b0, 3'd7);
    end

    ill_op = 1;
    @(negedge clk);
    ill_op = 0;
    @(negedge clk);
    expect_out("R6 illegal start", 1'b1, 3'd1);
    trap_exec = 1; sleep_exec = 1; sby_slp_ie = 1; addr_err = 1; insn_done = 1;
    @(negedge clk);
    idle_inputs();
    expect_out("R5 held while busy", 1'b0, 3'd1);
    @(negedge clk);
    expect_out("R5 still held", 1'b0, 3'd1);
    foreach (VREQ[j]) if (j < 3) begin
      logic [2:0] want;
      want = (j == 0) ? 3'd3 : (j == 1) ? 3'd5 : 3'd6;
      entry_done = 1;
      @(negedge clk);
      entry_done = 0;
      @(negedge clk);
      expect_out($sformatf("R4 queued order step %0d", j), 1'b1, want);
    end
    drain();

    ill_op = 1;
    @(negedge clk);
    ill_op = 0;
    @(negedge clk);
    expect_out("R6 illegal before trace", 1'b1, 3'd1);
    entry_done = 1; trace_en = 1; int_mode = 2'd2;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    expect_out("R8 trace after exception entry", 1'b1, 3'd2);
    drain();

    trap_exec = 1;
    @(negedge clk);
    trap_exec = 0;
    @(negedge clk);
    expect_out("R10 trap start", 1'b1, 3'd6);
    res_n = 0;
    @(negedge clk);
    expect_bit("R1 in_reset mid-entry", in_reset, 1'b1);
    expect_out("R1 entry abandoned", 1'b0, 3'd7);
    res_n = 1;
    @(negedge clk);
    expect_out("R1 reset after abandon", 1'b1, 3'd0);
    drain();
    expect_out("R4 nothing left", 1'b0, 3'd7);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule